// File: doc/BRIEF.md
# Iterative 64-bit Multiplier with Fit Flags

This unit multiplies two 64-bit operands into a full 128-bit product over a fixed number of clocks. The operands are read as unsigned or as two's-complement values, depending on a mode input. A form input selects one of two output forms. The widening form produces both product halves and asserts a write enable for the high half. The truncating forms deliver only the low half as the destination value. The high half is still computed, and it is what tells whether the result fit.

One truncating form takes its second operand from the lower 32 bits of `op_b`, sign-extended to 64 bits. The unit also produces carry, overflow, sign, zero and parity results, with an auxiliary carry that is always cleared. Carry and overflow together report that the product did not fit in the low half. The other flags describe the low half the same way a logic operation would.

Internally the unit takes operand magnitudes and runs one shift-add step per clock. On a signed product with mixed signs it negates the 128-bit result. A small state machine sequences the work through three states:
- **ST_IDLE** waits for `start`. Transition *accept* goes to ST_STEP when `start` is high.
- **ST_STEP** performs one shift-add per clock. Transition *last_step* goes to ST_SETTLE after step 64.
- **ST_SETTLE** applies the sign fix, registers the results and flags, and raises `done`. Transition *finish* returns to ST_IDLE unconditionally.

Top module: `wide_mul_unit`

## Requirements
- R1: With `form` = 2'b00 (widening), `prod_lo` equals the low 64 bits of the product, `prod_hi` equals the high 64 bits, and `wr_hi` is 1 while `done` is high.
- R2: With `is_signed` = 0, both `flag_cf` and `flag_of` are 1 exactly when the high 64 bits of the unsigned product are nonzero.
- R3: With `is_signed` = 1, the product is the 128-bit two's-complement product. `flag_cf` and `flag_of` are both 1 exactly when `prod_hi` differs from 64 copies of bit 63 of `prod_lo`.
- R4: `flag_sf` equals bit 63 of `prod_lo`. `flag_zf` is 1 when `prod_lo` is zero. `flag_pf` is 1 when bits 7..0 of `prod_lo` hold an even number of ones. `flag_af` is 0.
- R5: With `form` = 2'b01, 2'b10 or 2'b11 (truncating), `wr_hi` is 0. `prod_hi` still shows the high half, and carry and overflow are computed from it.
- R6: With `form` = 2'b10, the second operand is `op_b[31:0]` sign-extended to 64 bits, and `op_b[63:32]` has no effect on any output.
- R7: `done` is high for exactly one cycle, 65 clocks after the edge that samples `start`. The results remain on the outputs until the next completion.
- R8: A `start` pulse while an operation is in progress is ignored. The running result is not disturbed and no extra `done` follows.
- R9: A synchronous active-high `rst` returns the unit to idle and clears `done`, `wr_hi`, both product halves and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| is_signed | input | 1 | 1 = two's-complement operands |
| form | input | 2 | 00 widening, 01 truncating, 10 truncating with 32-bit immediate, 11 truncating |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand (or immediate in bits 31..0) |
| prod_lo | output | 64 | Low half of product |
| prod_hi | output | 64 | High half of product |
| wr_hi | output | 1 | High half is a written result |
| flag_cf | output | 1 | Carry: product does not fit low half |
| flag_of | output | 1 | Overflow: same as carry |
| flag_sf | output | 1 | Sign of low half |
| flag_zf | output | 1 | Low half is zero |
| flag_pf | output | 1 | Even parity of low byte |
| flag_af | output | 1 | Auxiliary carry, always 0 |
| done | output | 1 | One-cycle completion pulse |

## Verification
The stimulus uses random 64-bit operand pairs, some narrowed to small or negative values so that both fitting and overflowing products occur in each mode. Directed cases cover zero, all-ones, the most negative value squared, the most negative value times one, and minus one times one. Together these separate an unsigned fit test from a signed sign-extension test, and show whether the negation step is correct at its extremes. The immediate form is driven with random junk in the upper operand bits to show that sign extension comes only from bit 31. A second `start` during a run and the cycle after `done` show the busy guard and that the result is held.

// File: rtl/wmul_pkg.sv
package wmul_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STEP   = 2'd1,
        ST_SETTLE = 2'd2
    } wmul_state_e;

    typedef enum logic [1:0] {
        FORM_WIDE      = 2'b00,
        FORM_TRUNC     = 2'b01,
        FORM_TRUNC_IMM = 2'b10,
        FORM_TRUNC_ALT = 2'b11
    } wmul_form_e;
endpackage

// File: rtl/wmul_operand_prep.sv
module wmul_operand_prep
    import wmul_pkg::*;
#(
    parameter int W     = 64,
    parameter int IMM_W = 32
) (
    input  logic         is_signed,
    input  logic [1:0]   form,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] mag_a,
    output logic [W-1:0] mag_b,
    output logic         negate
);
    localparam int EXT_W = W - IMM_W;

    logic [W-1:0] b_eff;

    // R6: immediate form widens the low IMM_W bits by their top bit
    always_comb begin
        if (form == FORM_TRUNC_IMM)
            b_eff = {{EXT_W{op_b[IMM_W-1]}}, op_b[IMM_W-1:0]};
        else
            b_eff = op_b;
    end

    always_comb begin
        mag_a  = (is_signed && op_a[W-1])  ? (~op_a + 1'b1)  : op_a;
        mag_b  = (is_signed && b_eff[W-1]) ? (~b_eff + 1'b1) : b_eff;
        negate = is_signed && (op_a[W-1] ^ b_eff[W-1]);
    end
endmodule

// File: rtl/wmul_shift_add_core.sv
module wmul_shift_add_core #(
    parameter int W = 64
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    logic [W-1:0]  mcand_q;
    logic [PW-1:0] prod_q;
    logic [W:0]    partial;

    always_comb begin
        partial = {1'b0, prod_q[PW-1:W]} + (prod_q[0] ? {1'b0, mcand_q} : {(W+1){1'b0}});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            prod_q  <= '0;
        end else if (load) begin
            mcand_q <= mcand_in;
            prod_q  <= {{W{1'b0}}, mplier_in};
        end else if (step) begin
            prod_q  <= {partial, prod_q[W-1:1]};
        end
    end

    assign prod = prod_q;

    // R1: the accumulating half starts from zero after a load
    AST_LOAD_CLEARS_ACC: assert property (@(posedge clk) disable iff (rst)
        load |=> (prod_q[PW-1:W] == '0)); // R1
endmodule

// File: rtl/wmul_flag_gen.sv
module wmul_flag_gen #(
    parameter int W = 64
) (
    input  logic         is_signed,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic         no_fit,
    output logic         sign,
    output logic         zero,
    output logic         parity
);
    always_comb begin
        if (is_signed)
            no_fit = (hi + {{(W-1){1'b0}}, lo[W-1]}) != '0;
        else
            no_fit = |hi;
        sign   = lo[W-1];
        zero   = (lo == '0);
        parity = ~^lo[7:0];
    end
endmodule

// File: rtl/wide_mul_unit.sv
module wide_mul_unit
    import wmul_pkg::*;
#(
    parameter int W     = 64,
    parameter int IMM_W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         is_signed,
    input  logic [1:0]   form,
    input  logic [63:0]  op_a,
    input  logic [63:0]  op_b,
    output logic [63:0]  prod_lo,
    output logic [63:0]  prod_hi,
    output logic         wr_hi,
    output logic         flag_cf,
    output logic         flag_of,
    output logic         flag_sf,
    output logic         flag_zf,
    output logic         flag_pf,
    output logic         flag_af,
    output logic         done
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(W - 1);

    wmul_state_e      state_q, state_d;
    logic [CNT_W-1:0] step_cnt;
    logic             sgn_q, wide_q, negate_q;
    logic [W-1:0]     mag_a, mag_b;
    logic             negate;
    logic [2*W-1:0]   raw_prod, fixed_prod;
    logic             no_fit, f_sign, f_zero, f_par;
    logic             accept, load, step;

    assign accept = (state_q == ST_IDLE) && start;
    assign load   = accept;
    assign step   = (state_q == ST_STEP);

    wmul_operand_prep #(.W(W), .IMM_W(IMM_W)) u_prep (
        .is_signed (is_signed),
        .form      (form),
        .op_a      (op_a),
        .op_b      (op_b),
        .mag_a     (mag_a),
        .mag_b     (mag_b),
        .negate    (negate)
    );

    wmul_shift_add_core #(.W(W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .step      (step),
        .mcand_in  (mag_a),
        .mplier_in (mag_b),
        .prod      (raw_prod)
    );

    assign fixed_prod = negate_q ? (~raw_prod + 1'b1) : raw_prod;

    wmul_flag_gen #(.W(W)) u_flags (
        .is_signed (sgn_q),
        .lo        (fixed_prod[W-1:0]),
        .hi        (fixed_prod[2*W-1:W]),
        .no_fit    (no_fit),
        .sign      (f_sign),
        .zero      (f_zero),
        .parity    (f_par)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_d_apply: state_q <= state_d;
    end

    // next-state: accept, last_step, finish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_STEP;
            ST_STEP:   if (step_cnt == LAST_STEP) state_d = ST_SETTLE;
            ST_SETTLE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // operation context and step counter
    always_ff @(posedge clk) begin
        if (rst) begin
            step_cnt <= '0;
            sgn_q    <= 1'b0;
            wide_q   <= 1'b0;
            negate_q <= 1'b0;
        end else if (accept) begin
            step_cnt <= '0;
            sgn_q    <= is_signed;
            wide_q   <= (form == FORM_WIDE);
            negate_q <= negate;
        end else if (step) begin
            step_cnt <= step_cnt + 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            prod_lo <= '0;
            prod_hi <= '0;
            wr_hi   <= 1'b0;
            flag_cf <= 1'b0;
            flag_of <= 1'b0;
            flag_sf <= 1'b0;
            flag_zf <= 1'b0;
            flag_pf <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state_q == ST_SETTLE) begin
                prod_lo <= fixed_prod[W-1:0];
                prod_hi <= fixed_prod[2*W-1:W];
                wr_hi   <= wide_q;
                flag_cf <= no_fit;
                flag_of <= no_fit;
                flag_sf <= f_sign;
                flag_zf <= f_zero;
                flag_pf <= f_par;
                done    <= 1'b1;
            end
        end
    end

    assign flag_af = 1'b0;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_NO_DONE_IN_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STEP) |-> !done); // R7
    AST_CF_MATCHES_OF: assert property (@(posedge clk) disable iff (rst)
        done |-> (flag_cf == flag_of)); // R2
    AST_UNSIGNED_CARRY: assert property (@(posedge clk) disable iff (rst)
        (done && !sgn_q) |-> (flag_cf == (prod_hi != '0))); // R2
    AST_SIGNED_CARRY: assert property (@(posedge clk) disable iff (rst)
        (done && sgn_q) |-> (flag_cf == (prod_hi != {W{prod_lo[W-1]}}))); // R3
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        done |-> (flag_zf == (prod_lo == '0))); // R4
    AST_WIDE_WRITE: assert property (@(posedge clk) disable iff (rst)
        done |-> (wr_hi == wide_q)); // R5
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> ($stable(negate_q) && $stable(wide_q) && $stable(sgn_q))); // R8
endmodule

// File: tb/wide_mul_unit_tb.sv
module wide_mul_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        is_signed;
    logic [1:0]  form;
    logic [63:0] op_a, op_b;
    logic [63:0] prod_lo, prod_hi;
    logic        wr_hi, flag_cf, flag_of, flag_sf, flag_zf, flag_pf, flag_af, done;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    wide_mul_unit u_dut (
        .clk(clk), .rst(rst), .start(start), .is_signed(is_signed), .form(form),
        .op_a(op_a), .op_b(op_b), .prod_lo(prod_lo), .prod_hi(prod_hi), .wr_hi(wr_hi),
        .flag_cf(flag_cf), .flag_of(flag_of), .flag_sf(flag_sf), .flag_zf(flag_zf),
        .flag_pf(flag_pf), .flag_af(flag_af), .done(done)
    );

    function automatic logic [127:0] ref_prod(input logic sgn, input logic [1:0] f,
                                              input logic [63:0] a, input logic [63:0] b);
        logic [63:0]  be;
        logic [127:0] xa, xb;
        be = (f == 2'b10) ? {{32{b[31]}}, b[31:0]} : b;
        xa = sgn ? {{64{a[63]}}, a}  : {64'b0, a};
        xb = sgn ? {{64{be[63]}}, be} : {64'b0, be};
        return xa * xb;
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic sgn, input logic [1:0] f, input logic [63:0] a, input logic [63:0] b);
        logic [127:0] p;
        logic [63:0]  lo, hi;
        logic         nf;
        int           lat;
        bit           seen;
        string        rq;
        p  = ref_prod(sgn, f, a, b);
        lo = p[63:0];
        hi = p[127:64];
        nf = sgn ? (hi != {64{lo[63]}}) : (hi != 64'b0);
        rq = sgn ? "R3" : "R2";
        @(negedge clk);
        start = 1'b1; is_signed = sgn; form = f; op_a = a; op_b = b;
        @(posedge clk);
        lat = 0; seen = 1'b0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (done) begin seen = 1'b1; break; end
            @(posedge clk);
            lat++;
        end
        chk("R7", "done seen", 64'(seen), 64'd1);
        if (!seen) return;
        chk("R7", "latency", 64'(lat), 64'd65);
        chk((f == 2'b00) ? "R1" : rq, "prod_lo", prod_lo, lo);
        chk((f == 2'b00) ? "R1" : "R5", "prod_hi", prod_hi, hi);
        chk((f == 2'b00) ? "R1" : "R5", "wr_hi", 64'(wr_hi), 64'(f == 2'b00));
        chk(rq, "flag_cf", 64'(flag_cf), 64'(nf));
        chk(rq, "flag_of", 64'(flag_of), 64'(nf));
        chk("R4", "flags sf/zf/pf/af", {60'b0, flag_sf, flag_zf, flag_pf, flag_af},
            {60'b0, lo[63], lo == 64'b0, ~^lo[7:0], 1'b0});
        @(posedge clk);
        @(negedge clk);
        chk("R7", "done after pulse", 64'(done), 64'd0);
        chk("R7", "held prod_lo", prod_lo, lo);
    endtask

    function automatic logic [63:0] rnd64(input int kind);
        logic [63:0] v;
        v = {$urandom, $urandom};
        case (kind)
            0: return v;
            1: return {56'b0, v[7:0]};
            2: return {{48{1'b1}}, v[15:0]};
            default: return {{32{v[31]}}, v[31:0]};
        endcase
    endfunction

    initial begin
        #(4ns * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; start = 1'b0; is_signed = 1'b0; form = 2'b00; op_a = '0; op_b = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        chk("R9", "done", 64'(done), 64'd0);
        chk("R9", "wr_hi", 64'(wr_hi), 64'd0);
        chk("R9", "prod_lo", prod_lo, 64'd0);
        chk("R9", "prod_hi", prod_hi, 64'd0);
        chk("R9", "flags", {59'b0, flag_cf, flag_of, flag_sf, flag_zf, flag_pf},  64'd0);

        // directed corners
        run_op(1'b0, 2'b00, 64'd0, 64'hDEAD_BEEF_0000_1234);            // R1 R4 zero
        run_op(1'b0, 2'b00, '1, '1);                                     // R2 max*max
        run_op(1'b0, 2'b00, 64'h1_0000_0000, 64'h1_0000_0000);           // R2 hi=1 lo=0
        run_op(1'b1, 2'b00, '1, '1);                                     // R3 -1*-1
        run_op(1'b1, 2'b00, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000); // R3 min*min
        run_op(1'b1, 2'b01, 64'h8000_0000_0000_0000, 64'd1);             // R3 R5 fits
        run_op(1'b1, 2'b01, '1, 64'd1);                                  // R3 no overflow
        run_op(1'b1, 2'b10, 64'd7, 64'hFFFF_FFFF_FFFF_FFFE);             // R6 imm -2
        run_op(1'b1, 2'b10, 64'd7, 64'h1234_5678_FFFF_FFFE);             // R6 upper junk
        run_op(1'b1, 2'b10, 64'h4000_0000_0000_0000, 64'hABCD_0000_7FFF_FFFF); // R6 R3 overflow
        run_op(1'b0, 2'b11, 64'hFFFF_FFFF, 64'hFFFF_FFFF);               // R5 alt form

        // constrained random
        for (int n = 0; n < 40; n++) begin
            logic [1:0] f;
            f = 2'($urandom_range(0, 3));
            run_op(1'($urandom_range(0, 1)), f,
                   rnd64($urandom_range(0, 3)), rnd64($urandom_range(0, 3)));
        end

        // R8: second start while busy is ignored
        begin
            logic [127:0] p;
            int dones;
            p = ref_prod(1'b1, 2'b00, 64'hFFFF_FFFF_FFFF_FFF3, 64'd1000);
            @(negedge clk);
            start = 1'b1; is_signed = 1'b1; form = 2'b00;
            op_a = 64'hFFFF_FFFF_FFFF_FFF3; op_b = 64'd1000;
            @(negedge clk);
            start = 1'b0;
            repeat (10) @(negedge clk);
            start = 1'b1; is_signed = 1'b0; form = 2'b01; op_a = '1; op_b = '1;
            @(negedge clk);
            start = 1'b0;
            dones = 0;
            for (int k = 0; k < 200; k++) begin
                @(negedge clk);
                if (done) begin
                    dones++;
                    if (dones == 1) begin
                        chk("R8", "busy prod_lo", prod_lo, p[63:0]);
                        chk("R8", "busy prod_hi", prod_hi, p[127:64]);
                        chk("R8", "busy wr_hi", 64'(wr_hi), 64'd1);
                    end
                end
            end
            chk("R8", "done count", 64'(dones), 64'd1);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule